// File: doc/BRIEF.md
# Binary-Tree 32:1 Word Serializer

This block turns a 32-bit parallel word into one serial bit stream at the fast bit-clock rate. It uses five cascaded 2:1 selection stages arranged as a binary tree. Each stage halves the number of lanes and doubles the rate at which they change. The first four stages are clock-enabled registers. The fifth stage picks one of the two remaining lanes on every bit-clock cycle. All stage clocks are modelled as enable and phase strobes, derived from one free-running 5-bit counter on the bit clock.

The word is captured only in the word slot. The word slot is the one bit-clock cycle in 32 where the counter is zero, and the block flags it on `wordSlot`. A source feeding back-to-back words asserts `wordLoad` with the next word in each slot, and the serial stream then has no gaps. The last stage has a 2-bit delay select. It retimes the final selection by 0 to 3 bit-clock cycles, so that its sampling point can be moved to recover setup and hold margin.

Top module: `tree_serializer`

## Requirements
- R1: While `rst` is high, and after it falls, `serOut` is 0 and the word register holds zero. The output stays 0 until a nonzero word has been loaded and has passed through the tree.
- R2: `wordSlot` is high in the first cycle after reset is released, and then in exactly one cycle out of every 32.
- R3: A captured word leaves on `serOut` least significant bit first. Bit 0 comes first and bit 31 last, one bit per bit-clock cycle.
- R4: With `dlySel` = 0, bit 0 of a word loaded in slot cycle s appears on `serOut` in cycle s+6.
- R5: Words loaded in consecutive slots come out as one continuous 64-bit stream. There is no gap and no repeated bit.
- R6: `wordLoad` asserted outside the word slot has no effect on the word being transmitted.
- R7: A slot without `wordLoad` retransmits the previously captured word.
- R8: A `dlySel` value d adds exactly d bit-clock cycles to the latency, so bit 0 appears in cycle s+6+d. The value of `dlySel` during cycle c-1 sets the tap for `serOut` in cycle c. When `dlySel` changes, `serOut` continues the undelayed stream from its new tap, so only bits at the switch point are dropped or repeated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; one serial bit per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wordLoad | input | 1 | Load request, honoured only in the word slot |
| wordIn | input | 32 | Parallel word, bit 0 is sent first |
| dlySel | input | 2 | Retiming taps on the last stage, 0 to 3 cycles |
| wordSlot | output | 1 | High in the cycle where a load is accepted |
| serOut | output | 1 | Serial data output |

## Verification
The bench feeds single-bit words at both ends (bit 0 only, bit 31 only). These show whether lane pairing is LSB-first or bit-reversed, and they expose an off-by-one in latency. Dense and mixed patterns, including all-ones next to all-zeros in consecutive slots, show a dropped or repeated bit at the word boundary. Junk loads placed between slots, and empty slots, show whether capture is truly gated by the slot. Latency is measured for each of the four delay taps. A run that switches taps mid-word is compared cycle by cycle against a behavioural model of the delayed stream.

// File: rtl/tree_ser_pkg.sv
package tree_ser_pkg;
  localparam int LEVELS = 5;
  localparam int WORD_W = 1 << LEVELS;
  localparam int TAPS   = 4;
  localparam int SEL_W  = $clog2(TAPS);
  localparam int TAP_W  = 3;  // {phase, upperLane, lowerLane}

  typedef struct packed {
    logic              load;
    logic [LEVELS-1:0] stageEn;
    logic [LEVELS-1:0] stagePhase;
  } strobe_t;
endpackage

// File: rtl/tree_ser_ctrl.sv
module tree_ser_ctrl
  import tree_ser_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    wordLoad,
  output logic    wordSlot,
  output strobe_t strobes
);
  logic [LEVELS-1:0] bitCnt;
  logic [LEVELS-1:0] enVec;
  logic [LEVELS-1:0] phVec;

  always_ff @(posedge clk) begin
    if (rst) bitCnt <= '0;
    else     bitCnt <= bitCnt + 1'b1;
  end

  assign wordSlot = (bitCnt == '0);

  // Stage k fires k cycles after the slot, then every 2^(5-k) cycles.
  // Its phase selects the lower half first, then the upper half.
  for (genvar i = 0; i < LEVELS; i++) begin : gStage
    localparam int HOLD_W = LEVELS - 1 - i;
    logic [LEVELS-1:0] rel;
    assign rel = bitCnt - LEVELS'(i + 1);
    if (HOLD_W == 0) begin : gFast
      assign enVec[i] = 1'b1;
    end else begin : gSlow
      assign enVec[i] = (rel[HOLD_W-1:0] == '0);
    end
    assign phVec[i] = rel[HOLD_W];
  end

  assign strobes = '{load: wordLoad && wordSlot, stageEn: enVec, stagePhase: phVec};
endmodule

// File: rtl/tree_ser_dp.sv
module tree_ser_dp
  import tree_ser_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] wordIn,
  input  logic [SEL_W-1:0]  dlySel,
  input  strobe_t           strobes,
  output logic [WORD_W-1:0] wordQ,
  output logic              serOut
);
  // Level 0 holds the captured word; level L holds WORD_W>>L lanes.
  logic [WORD_W-1:0] lvl [0:LEVELS-1];

  always_ff @(posedge clk) begin
    if (rst)               lvl[0] <= '0;
    else if (strobes.load) lvl[0] <= wordIn;
  end

  for (genvar L = 1; L < LEVELS; L++) begin : gLvl
    localparam int LW = WORD_W >> L;
    always_ff @(posedge clk) begin
      if (rst) begin
        lvl[L] <= '0;
      end else if (strobes.stageEn[L-1]) begin
        if (strobes.stagePhase[L-1]) lvl[L] <= WORD_W'(lvl[L-1][2*LW-1:LW]);
        else                         lvl[L] <= WORD_W'(lvl[L-1][LW-1:0]);
      end
    end
  end

  // Final 2:1 stage: retime lane pair and select phase together.
  logic [TAP_W-1:0] curTap;
  logic [TAP_W-1:0] tapped;
  logic [TAP_W-1:0] tapLine [1:TAPS-1];

  assign curTap = {strobes.stagePhase[LEVELS-1], lvl[LEVELS-1][1:0]};

  for (genvar j = 1; j < TAPS; j++) begin : gTap
    always_ff @(posedge clk) begin
      if (rst)    tapLine[j] <= '0;
      else if (j == 1) tapLine[j] <= curTap;
      else        tapLine[j] <= tapLine[j-1];
    end
  end

  always_comb begin
    tapped = curTap;
    for (int j = 1; j < TAPS; j++)
      if (dlySel == SEL_W'(j)) tapped = tapLine[j];
  end

  always_ff @(posedge clk) begin
    if (rst)                              serOut <= 1'b0;
    else if (strobes.stageEn[LEVELS-1])   serOut <= tapped[2] ? tapped[1] : tapped[0];
  end

  assign wordQ = lvl[0];
endmodule

// File: rtl/tree_serializer.sv
module tree_serializer
  import tree_ser_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wordLoad,
  input  logic [WORD_W-1:0] wordIn,
  input  logic [SEL_W-1:0]  dlySel,
  output logic              wordSlot,
  output logic              serOut
);
  strobe_t           strobes;
  logic [WORD_W-1:0] capWordQ;

  tree_ser_ctrl uCtrl (
    .clk      (clk),
    .rst      (rst),
    .wordLoad (wordLoad),
    .wordSlot (wordSlot),
    .strobes  (strobes)
  );

  tree_ser_dp uDp (
    .clk     (clk),
    .rst     (rst),
    .wordIn  (wordIn),
    .dlySel  (dlySel),
    .strobes (strobes),
    .wordQ   (capWordQ),
    .serOut  (serOut)
  );
endmodule

// File: rtl/tree_ser_chk.sv
module tree_ser_chk
  import tree_ser_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              wordLoad,
  input logic [WORD_W-1:0] wordIn,
  input logic              wordSlot,
  input logic              serOut,
  input logic [WORD_W-1:0] capWordQ
);
  logic [LEVELS:0] gapCnt;
  logic            seenSlot;

  always_ff @(posedge clk) begin
    if (rst) begin
      gapCnt   <= '0;
      seenSlot <= 1'b0;
    end else if (wordSlot) begin
      gapCnt   <= '0;
      seenSlot <= 1'b1;
    end else begin
      gapCnt   <= gapCnt + 1'b1;
    end
  end

  AST_RESET_LOW: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!serOut && capWordQ == '0)); // R1

  AST_SLOT_PERIOD: assert property (@(posedge clk) disable iff (rst)
    (wordSlot && seenSlot) |-> (gapCnt == (LEVELS+1)'(WORD_W - 1))); // R2

  AST_SLOT_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (wordSlot && wordLoad) |=> (capWordQ == $past(wordIn))); // R4

  AST_OFFSLOT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!wordSlot && wordLoad) |=> $stable(capWordQ)); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wordSlot && !wordLoad) |=> $stable(capWordQ)); // R7
endmodule

bind tree_serializer tree_ser_chk uChk (
  .clk      (clk),
  .rst      (rst),
  .wordLoad (wordLoad),
  .wordIn   (wordIn),
  .wordSlot (wordSlot),
  .serOut   (serOut),
  .capWordQ (capWordQ)
);

// File: tb/sim_tree_serializer.sv
module sim_tree_serializer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wordLoad = 1'b0;
  logic [31:0] wordIn = '0;
  logic [1:0]  dlySel = '0;
  logic        wordSlot;
  logic        serOut;

  tree_serializer u0 (
    .clk(clk), .rst(rst), .wordLoad(wordLoad), .wordIn(wordIn),
    .dlySel(dlySel), .wordSlot(wordSlot), .serOut(serOut)
  );

  always #4 clk = ~clk;

  int          nChecks = 0;
  int          nFail = 0;
  string       curReq = "R1";
  int          cntM = 0;
  logic [31:0] capWord = '0;
  logic [31:0] outWord = '0;
  logic [3:0]  hist = '0;

  task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", curReq, what, act, exp, cntM);
    end
  endtask

  // One bit-clock cycle; called and returning at a falling edge.
  task automatic tick(input logic ld, input logic [31:0] dat, input logic [1:0] d, output logic obs);
    logic undel;
    if (cntM == 6) outWord = capWord;
    undel = outWord[(cntM + 26) % 32];
    hist = {hist[2:0], undel};
    obs = serOut;
    check(serOut === hist[dlySel], "serial bit", 64'(serOut), 64'(hist[dlySel]));
    check(wordSlot === (cntM == 0), "word slot (R2)", 64'(wordSlot), 64'(cntM == 0));
    wordLoad = ld;
    wordIn = dat;
    dlySel = d;
    if (ld && cntM == 0) capWord = dat;
    cntM = (cntM + 1) % 32;
    @(negedge clk);
  endtask

  task automatic alignSlot();
    logic o;
    while (cntM != 0) tick(1'b0, 32'h0, dlySel, o);
  endtask

  task automatic runPair(input logic ld1, input logic [31:0] w1, input logic ld2,
                         input logic [31:0] w2, input logic junk, input logic [1:0] d,
                         input logic [63:0] exp64);
    logic [63:0] rec;
    logic o;
    rec = '0;
    alignSlot();
    for (int t = 0; t <= 69 + d; t++) begin
      logic ld;
      logic [31:0] dat;
      ld = 1'b0;
      dat = '0;
      if (t == 0 && ld1) begin ld = 1'b1; dat = w1; end
      if (t == 32 && ld2) begin ld = 1'b1; dat = w2; end
      if (junk && ((t % 32) == 3 || (t % 32) == 17 || (t % 32) == 29)) begin
        ld = 1'b1;
        dat = 32'hDEAD_BEEF ^ 32'(t);
      end
      tick(ld, dat, d, o);
      if (t >= 6 + d && t < 70 + d) rec[t - 6 - d] = o;
    end
    check(rec == exp64, "64-bit serial stream", rec, exp64);
    alignSlot();
  endtask

  task automatic measureLatency(input logic [1:0] d);
    logic o;
    int lat;
    lat = -1;
    alignSlot();
    tick(1'b1, 32'h0, d, o);
    for (int t = 1; t < 32; t++) tick(1'b0, 32'h0, d, o);
    tick(1'b1, 32'h1, d, o);
    for (int j = 1; j <= 40; j++) begin
      tick(1'b0, 32'h0, d, o);
      if (o && lat < 0) lat = j;
    end
    check(lat == 6 + int'(d), "load-to-first-bit latency", 64'(lat), 64'(6 + int'(d)));
    alignSlot();
  endtask

  initial begin
    logic o;
    repeat (4) @(negedge clk);
    curReq = "R1";
    check(serOut === 1'b0, "output during reset", 64'(serOut), 64'h0);
    rst = 1'b0;
    for (int t = 0; t < 40; t++) begin
      tick(1'b0, 32'h0, 2'd0, o);
      check(o === 1'b0, "output low before first word", 64'(o), 64'h0);
    end

    curReq = "R3";
    runPair(1'b1, 32'h0000_0001, 1'b1, 32'h8000_0000, 1'b0, 2'd0, {32'h8000_0000, 32'h0000_0001});
    runPair(1'b1, 32'h1234_5678, 1'b1, 32'hA5A5_F00F, 1'b0, 2'd0, {32'hA5A5_F00F, 32'h1234_5678});

    curReq = "R5";
    runPair(1'b1, 32'hFFFF_FFFF, 1'b1, 32'h0000_0000, 1'b0, 2'd0, {32'h0000_0000, 32'hFFFF_FFFF});
    runPair(1'b1, 32'h0000_0000, 1'b1, 32'hFFFF_FFFF, 1'b0, 2'd0, {32'hFFFF_FFFF, 32'h0000_0000});
    runPair(1'b1, 32'h5555_5555, 1'b1, 32'hAAAA_AAAA, 1'b0, 2'd0, {32'hAAAA_AAAA, 32'h5555_5555});

    curReq = "R7";
    runPair(1'b1, 32'h0F1E_2D3C, 1'b0, 32'h0, 1'b0, 2'd0, {32'h0F1E_2D3C, 32'h0F1E_2D3C});

    curReq = "R6";
    runPair(1'b1, 32'h7E81_00FF, 1'b0, 32'h0, 1'b1, 2'd0, {32'h7E81_00FF, 32'h7E81_00FF});

    curReq = "R4";
    measureLatency(2'd0);
    curReq = "R8";
    measureLatency(2'd1);
    measureLatency(2'd2);
    measureLatency(2'd3);
    runPair(1'b1, 32'hC001_D00D, 1'b1, 32'h1357_9BDF, 1'b0, 2'd2, {32'h1357_9BDF, 32'hC001_D00D});
    runPair(1'b1, 32'h8000_0001, 1'b1, 32'h6996_0FF0, 1'b0, 2'd3, {32'h6996_0FF0, 32'h8000_0001});
    alignSlot();
    for (int t = 0; t < 96; t++)
      tick(t % 32 == 0, 32'hC3A5_1E7F + 32'(t), 2'((t / 13) % 4), o);

    curReq = "R1";
    alignSlot();
    runPair(1'b1, 32'hFFFF_FFFF, 1'b1, 32'hFFFF_FFFF, 1'b0, 2'd0, {64{1'b1}});
    for (int t = 0; t < 9; t++) tick(1'b0, 32'h0, 2'd0, o);
    rst = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check(serOut === 1'b0, "output cleared by reset", 64'(serOut), 64'h0);
    end
    rst = 1'b0;
    cntM = 0;
    capWord = '0;
    outWord = '0;
    hist = '0;
    for (int t = 0; t < 40; t++) begin
      tick(1'b0, 32'h0, 2'd0, o);
      check(o === 1'b0, "output low after reset", 64'(o), 64'h0);
    end

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL %s watchdog expired: actual running expected finished", curReq);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule